// File: doc/BRIEF.md
# Double-Buffered 10-Bit Pulse-Width Generator

The block drives one pulse-width-modulated output from an 8-bit period counter. A prescaler divides the input clock by 4, 16 or 64. Each count of the period counter therefore lasts 4 × P input clocks, where P is the selected prescale factor of 1, 4 or 16. The prescaler also yields a 2-bit quarter phase inside each count. The high time is compared against the period counter joined with that quarter phase, so the duty value has 10 bits of resolution while the period value has 8.

Software sets the period, the upper eight duty bits and a control byte through a small write port. The control byte holds the prescale code, a count-enable bit, the output-enable bit and the two lowest duty bits. The duty value passes through a shadow copy that is refreshed only when a period ends. This keeps a period from mixing an old and a new duty value. The upper eight bits of the shadow copy can be read but not written.

Top module: `pwm10_core`

## Requirements
- R1: After reset the output is low, and reads return zero from all four addresses: 0 period, 1 duty high byte, 2 control, 3 shadow high byte.
- R2: The control byte at address 2 has the prescale code in bits 1:0, count-enable in bit 2, output-enable in bit 3 and the duty low bits in bits 5:4. Bits 7:6 read as zero. With both enables set, one output period lasts 4 × P × (period + 1) input clocks.
- R3: The duty value D is {duty high byte, control bits 5:4}. When 0 < D < 4 × (period + 1), the output is high for D × P clocks from the start of each period and low for the rest of it.
- R4: A duty value written during a period takes effect only from the start of the next period. The current high phase is not changed.
- R5: A latched duty of zero keeps the output low for the whole period.
- R6: A latched duty of at least 4 × (period + 1) keeps the output high for the whole period.
- R7: Prescale code 0 selects P = 1, code 1 selects P = 4, and codes 2 and 3 both select P = 16.
- R8: When the output-enable bit is clear, the output goes low at the next clock edge and stays low.
- R9: Address 3 reads the upper eight bits of the shadow duty. Writes to address 3 have no effect.
- R10: With output-enable set and count-enable clear, the counters freeze and the output holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| pwm_out | output | 1 | Pulse-width output |

## Verification
Any slip in the prescaler count, the period counter or the quarter phase moves the falling edge of the output within the first period after enable. The same slip changes the spacing of the rising edges at the next period end. The reference model compares every clock, so such a fault shows within one period. A shadow copy refreshed at the wrong moment shows as a high phase of the wrong length in the period where the duty was rewritten. It also shows through the address-3 readback on the same cycle.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int TMR_W     = 8;
    localparam int FRAC_W    = 2;
    localparam int MAX_SHIFT = 4;

    typedef enum logic [1:0] {
        PS_1   = 2'd0,
        PS_4   = 2'd1,
        PS_16  = 2'd2,
        PS_16B = 2'd3
    } presc_e;

    typedef enum logic [1:0] {
        A_PERIOD  = 2'd0,
        A_DUTY_HI = 2'd1,
        A_CTRL    = 2'd2,
        A_SHADOW  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FRAC_W-1:0] duty_lo;
        logic              out_en;
        logic              cnt_en;
        presc_e            presc;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [2:0] presc_shift(presc_e p);
        case (p)
            PS_1:    return 3'd0;
            PS_4:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int DATA_W = TMR_W,
    parameter int DUTY_W = TMR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DUTY_W-1:0] shadow,
    output logic [DATA_W-1:0] period,
    output logic [DUTY_W-1:0] duty,
    output ctrl_t             ctrl
);

    logic [DATA_W-1:0] duty_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period    <= '0;
            duty_hi_q <= '0;
            ctrl      <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_PERIOD:  period    <= wr_data;
                A_DUTY_HI: duty_hi_q <= wr_data;
                A_CTRL:    ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    assign duty = {duty_hi_q, ctrl.duty_lo};

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_PERIOD:  rd_data = period;
            A_DUTY_HI: rd_data = duty_hi_q;
            A_CTRL:    rd_data = DATA_W'(ctrl);
            default:   rd_data = shadow[DUTY_W-1 -: DATA_W];
        endcase
    end

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int CNT_W  = TMR_W,
    parameter int SUB_W  = FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   active,
    input  presc_e                 presc,
    input  logic [CNT_W-1:0]       period,
    output logic                   wrap,
    output logic [CNT_W+SUB_W-1:0] pos_nx
);

    localparam int PC_W = SUB_W + MAX_SHIFT;

    logic [PC_W-1:0]  pc, pc_nx, last;
    logic [CNT_W-1:0] tmr, tmr_nx;
    logic [2:0]       shift;
    logic             tick;

    always_comb begin
        shift  = presc_shift(presc);
        last   = {PC_W{1'b1}} >> (3'(MAX_SHIFT) - shift);
        tick   = active && (pc >= last);
        wrap   = tick && (tmr == period);
        pc_nx  = !active ? pc : (tick ? '0 : pc + 1'b1);
        tmr_nx = wrap ? '0 : (tick ? tmr + 1'b1 : tmr);
        pos_nx = {tmr_nx, SUB_W'(pc_nx >> shift)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            tmr <= '0;
        end else begin
            pc  <= pc_nx;
            tmr <= tmr_nx;
        end
    end

    // R2: a period end restarts the counter at zero
    a_r2_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (tmr == '0));

    // R10: a stopped time base holds its count
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !active |=> ($stable(tmr) && $stable(pc)));

endmodule

// File: rtl/pwm10_output.sv
module pwm10_output
    import pwm10_pkg::*;
#(
    parameter int DUTY_W = TMR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_en,
    input  logic              active,
    input  logic              wrap,
    input  logic [DUTY_W-1:0] pos_nx,
    input  logic [DUTY_W-1:0] duty,
    output logic [DUTY_W-1:0] shadow,
    output logic              pwm_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            pwm_out <= 1'b0;
        end else begin
            if (wrap)
                shadow <= duty;
            if (!out_en)
                pwm_out <= 1'b0;
            else if (wrap)
                pwm_out <= |duty;
            else if (active && (pos_nx == shadow))
                pwm_out <= 1'b0;
        end
    end

    a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> !pwm_out);

    a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (wrap && (duty == '0)) |=> !pwm_out);

    a_r3_set_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (out_en && wrap && (duty != '0)) |=> pwm_out);

    a_r4_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(shadow));

    a_r10_hold_level: assert property (@(posedge clk) disable iff (rst)
        (out_en && !active) |=> $stable(pwm_out));

endmodule

// File: rtl/pwm10_core.sv
module pwm10_core
    import pwm10_pkg::*;
#(
    parameter int DATA_W = TMR_W,
    parameter int SUB_W  = FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    localparam int DUTY_W = DATA_W + SUB_W;

    logic [DATA_W-1:0] period;
    logic [DUTY_W-1:0] duty, shadow, pos_nx;
    ctrl_t             ctrl;
    logic              active, wrap;

    assign active = ctrl.out_en && ctrl.cnt_en;

    pwm10_regs #(.DATA_W(DATA_W), .DUTY_W(DUTY_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .shadow(shadow), .period(period), .duty(duty), .ctrl(ctrl)
    );

    pwm10_timebase #(.CNT_W(DATA_W), .SUB_W(SUB_W)) u_tb (
        .clk(clk), .rst(rst), .active(active), .presc(ctrl.presc),
        .period(period), .wrap(wrap), .pos_nx(pos_nx)
    );

    pwm10_output #(.DUTY_W(DUTY_W)) u_out (
        .clk(clk), .rst(rst), .out_en(ctrl.out_en), .active(active),
        .wrap(wrap), .pos_nx(pos_nx), .duty(duty), .shadow(shadow),
        .pwm_out(pwm_out)
    );

endmodule

// File: tb/pwm10_core_test.sv
`timescale 1ns/1ps
module pwm10_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int total = 0;
    int bad   = 0;

    pwm10_core uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    // behavioural reference
    int m_per, m_dh, m_dl, m_ps, m_run, m_en, m_q, m_t, m_sh, m_o;

    function automatic int pfac(int code);
        return (code == 0) ? 1 : ((code == 1) ? 4 : 16);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_per = 0; m_dh = 0; m_dl = 0; m_ps = 0; m_run = 0; m_en = 0;
            m_q = 0; m_t = 0; m_sh = 0; m_o = 0;
        end else begin
            if (m_en != 0 && m_run != 0) begin
                m_q = m_q + 1;
                if (m_q >= 4 * pfac(m_ps)) begin
                    m_q = 0;
                    if (m_t == m_per) begin
                        m_t = 0;
                        m_sh = m_dh * 4 + m_dl;
                        m_o = (m_sh != 0) ? 1 : 0;
                    end else begin
                        m_t = (m_t + 1) % 256;
                        if (m_t * 4 == m_sh) m_o = 0;
                    end
                end else if (m_t * 4 + m_q / pfac(m_ps) == m_sh) begin
                    m_o = 0;
                end
            end else if (m_en == 0) begin
                m_o = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_per = int'(wr_data);
                    2'd1: m_dh = int'(wr_data);
                    2'd2: begin
                        m_ps  = int'(wr_data) & 3;
                        m_run = (int'(wr_data) >> 2) & 1;
                        m_en  = (int'(wr_data) >> 3) & 1;
                        m_dl  = (int'(wr_data) >> 4) & 3;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            int exp_rd;
            case (rd_addr)
                2'd0: exp_rd = m_per;
                2'd1: exp_rd = m_dh;
                2'd2: exp_rd = (m_dl << 4) | (m_en << 3) | (m_run << 2) | m_ps;
                default: exp_rd = m_sh >> 2;
            endcase
            chk("R2 R3 model output", int'(pwm_out), m_o);
            chk("R9 model readback", int'(rd_data), exp_rd);
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 2'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_level(input logic lvl);
        int g = 0;
        while (pwm_out !== lvl && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic measure(output int hi, output int per);
        int g;
        wait_level(1'b0);
        wait_level(1'b1);
        hi = 0; per = 0; g = 0;
        while (pwm_out === 1'b1 && g < 20000) begin
            hi++; per++; g++;
            @(negedge clk);
        end
        while (pwm_out === 1'b0 && g < 20000) begin
            per++; g++;
            @(negedge clk);
        end
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out === 1'b1) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, hi, per;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 output", int'(pwm_out), 0);
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk("R1 readback", v, 0);
        end

        // R2/R3: period 9, duty 13, prescale 1
        wr(0, 9); wr(1, 3); wr(2, 8'h1C);
        rd(2, v);
        chk("R2 control layout", v, 8'h1C);
        measure(hi, per);
        measure(hi, per);
        chk("R3 high time P1", hi, 13);
        chk("R2 period P1", per, 40);

        // R9 shadow readback and write ignored
        rd(3, v);
        chk("R9 shadow read", v, 3);
        wr(3, 8'hAA);
        rd(3, v);
        chk("R9 shadow write ignored", v, 3);
        rd(0, v);
        chk("R9 period untouched", v, 9);

        // R4: rewrite duty to 30 right after the period starts
        wait_level(1'b0);
        wait_level(1'b1);
        hi = 1;
        wr(1, 7);  if (pwm_out === 1'b1) hi++;
        wr(2, 8'h2C); if (pwm_out === 1'b1) hi++;
        @(negedge clk);
        while (pwm_out === 1'b1 && hi < 1000) begin
            hi++;
            @(negedge clk);
        end
        chk("R4 current period unchanged", hi, 13);
        measure(hi, per);
        chk("R4 next period new duty", hi, 30);
        chk("R4 period kept", per, 40);

        // R5 zero duty
        wr(1, 0); wr(2, 8'h0C);
        repeat (80) @(negedge clk);
        count_high(80, hi);
        chk("R5 zero duty stays low", hi, 0);

        // R6 duty beyond period
        wr(1, 10);
        repeat (80) @(negedge clk);
        count_high(80, hi);
        chk("R6 full duty stays high", hi, 80);

        // R10 count stop holds level
        wr(2, 8'h08);
        count_high(60, hi);
        chk("R10 level held", hi, 60);
        rd(2, v);
        chk("R10 control read", v, 8'h08);

        // R8 disable forces low
        wr(2, 8'h00);
        @(negedge clk);
        chk("R8 low after disable", int'(pwm_out), 0);
        count_high(50, hi);
        chk("R8 stays low", hi, 0);

        // R7 prescale 4: period 4, duty 7
        wr(0, 4); wr(1, 1); wr(2, 8'h3D);
        measure(hi, per);
        measure(hi, per);
        chk("R7 high time P4", hi, 28);
        chk("R7 period P4", per, 80);

        // R7 prescale 16 (code 2): period 2, duty 5
        wr(0, 2); wr(2, 8'h1E);
        measure(hi, per);
        measure(hi, per);
        chk("R7 high time P16", hi, 80);
        chk("R7 period P16", per, 192);

        // R7 code 3 equals code 2
        wr(2, 8'h1F);
        measure(hi, per);
        measure(hi, per);
        chk("R7 high time code3", hi, 80);
        chk("R7 period code3", per, 192);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule